// File: doc/BRIEF.md
# Strobe-paced HyperBus burst read engine

This block is the master side of an 8-bit double-data-rate flash link and runs burst reads. When a host request (start address and word count) is taken, the engine pulls chip select low and toggles the bus clock once per controller clock, so one bus clock period spans two controller clocks. Over the first three bus clocks it drives a 48-bit command/address word, one byte per clock edge. It then waits out a programmable number of dummy edges. After that it stops counting and lets the device's read strobe decide when data is taken.

In the capture window a byte is latched only when the strobe changes level. A rising change gives the upper byte and the following falling change gives the lower byte, and each completed pair is emitted as a 16-bit word with a one-cycle valid pulse. The bus clock keeps running while the strobe is quiet. This covers a device whose initial latency is longer than the dummy setting and a device that pauses in mid-burst when it crosses an internal page. If the strobe stays still too long, the burst is aborted with an error. A static flag tells whether the current latency setting would be legal for write traffic, where the master has to drive the strobe itself and cannot wait on the device.

Top module: `hb_read_engine`

## Requirements
- R1: While reset is held, chip select is high, the bus clock is low, the data bus is not driven, and the valid, done and error outputs are low. After reset, req_ready is high.
- R2: An accepted request puts exactly six bytes on hb_dq_o with hb_dq_oe high, one per controller clock, most significant byte first. The 48-bit word is, from bit 47 down: 1 (read), 0 (memory space), 1 (linear burst), req_addr[31:3], thirteen zeros, then req_addr[2:0].
- R3: While chip select is low, hb_ck inverts on every controller clock, starting low in the first command cycle. While chip select is high, hb_ck is low.
- R4: For max(cfg_latency,1) controller clocks after the command phase, strobe levels and edges are ignored. Capture then starts with the strobe taken as low, so a latency indication the device drives high during command and dummy has no effect on the data.
- R5: In the capture window a strobe change from 0 to 1 latches hb_dq_i as the upper byte, and the next change from 1 to 0 latches the lower byte. The word {upper,lower} appears on rd_data with rd_valid high for one cycle. Cycles with no strobe change produce no word.
- R6: If the device starts its strobe later than the dummy count, the engine keeps clocking and delivers every word intact.
- R7: A strobe pause of any length below the timeout in the middle of a burst, at a word boundary, loses and duplicates no word.
- R8: If no strobe change is seen for 2*cfg_timeout controller clocks in the capture window, the burst ends: chip select rises, and rd_done and rd_err pulse together. Words delivered before that stand.
- R9: After req_len words, the final rd_valid cycle also carries rd_done with rd_err low, and chip select is high in that same cycle.
- R10: Between two bursts chip select stays high for at least two controller clocks (one bus clock). req_ready is high only while the engine is idle with chip select high.
- R11: wr_lat_ok is high exactly when cfg_latency >= WR_LAT_MIN (default 11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; one bus clock edge per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_latency | input | LAT_W | Dummy edges after the command phase (minimum 1 applied) |
| cfg_timeout | input | TO_W | Strobe silence limit in bus clocks, nonzero |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_addr | input | ADDR_W | Start address |
| req_len | input | LEN_W | Number of 16-bit words, nonzero |
| hb_cs_n | output | 1 | Chip select, active low |
| hb_ck | output | 1 | Bus clock |
| hb_dq_o | output | 8 | Command/address byte out |
| hb_dq_oe | output | 1 | Output enable for hb_dq_o |
| hb_dq_i | input | 8 | Data byte from the device |
| hb_rwds_i | input | 1 | Read strobe from the device |
| rd_valid | output | 1 | One-cycle pulse per captured word |
| rd_data | output | 16 | Captured word |
| rd_done | output | 1 | Burst finished (normal or aborted) |
| rd_err | output | 1 | Burst aborted by strobe timeout |
| wr_lat_ok | output | 1 | Latency setting satisfies the write minimum |

## Verification
The hardest case to reach is a pause at a page boundary in the middle of a burst, with the strobe frozen at its low level between two words. This is made worse when it comes together with a late first strobe and a latency indication held high through the dummy window. The bench contains a reactive device model that counts clocks from the fall of chip select and is given an initial latency, an indication length, a pause position and a pause length for each vector. It can also stop strobing early, which drives the engine into its timeout both after a few words and before the first one.

// File: rtl/hb_read_pkg.sv
package hb_read_pkg;

    localparam int CA_W     = 48;
    localparam int CA_BYTES = CA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DUMMY,
        ST_CAPT,
        ST_GAP
    } hb_state_e;

    // read, memory space, linear burst, upper address, reserved, low address
    function automatic logic [CA_W-1:0] build_ca(input logic [31:0] a);
        return {1'b1, 1'b0, 1'b1, a[31:3], 13'd0, a[2:0]};
    endfunction

endpackage

// File: rtl/hb_strobe_capture.sv
module hb_strobe_capture (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm_i,
    input  logic        en_i,
    input  logic        rwds_i,
    input  logic [7:0]  dq_i,
    output logic        edge_o,
    output logic        word_vld_o,
    output logic [15:0] word_o
);

    typedef struct packed {
        logic       lvl;
        logic [7:0] hi;
    } cap_t;

    cap_t cap_d, cap_q;

    assign edge_o     = en_i && (rwds_i != cap_q.lvl);
    assign word_vld_o = edge_o && cap_q.lvl;
    assign word_o     = {cap_q.hi, dq_i};

    always_comb begin
        cap_d = cap_q;
        if (arm_i) begin
            cap_d.lvl = 1'b0;
        end else if (edge_o) begin
            cap_d.lvl = ~cap_q.lvl;
            if (!cap_q.lvl) begin
                cap_d.hi = dq_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    // a word may only complete on a falling strobe sample
    AST_WORD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> !rwds_i); // R5

endmodule

// File: rtl/hb_wr_latency_check.sv
module hb_wr_latency_check #(
    parameter int LAT_W      = 5,
    parameter int WR_LAT_MIN = 11
) (
    input  logic [LAT_W-1:0] cfg_latency,
    output logic             wr_lat_ok
);

    localparam logic [LAT_W-1:0] MIN_L = LAT_W'(WR_LAT_MIN);

    assign wr_lat_ok = (cfg_latency >= MIN_L);

endmodule

// File: rtl/hb_read_engine.sv
module hb_read_engine
    import hb_read_pkg::*;
#(
    parameter int LAT_W      = 5,
    parameter int TO_W       = 8,
    parameter int LEN_W      = 8,
    parameter int ADDR_W     = 32,
    parameter int WR_LAT_MIN = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAT_W-1:0]  cfg_latency,
    input  logic [TO_W-1:0]   cfg_timeout,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              hb_cs_n,
    output logic              hb_ck,
    output logic [7:0]        hb_dq_o,
    output logic              hb_dq_oe,
    input  logic [7:0]        hb_dq_i,
    input  logic              hb_rwds_i,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic              rd_done,
    output logic              rd_err,
    output logic              wr_lat_ok
);

    localparam int SEQ_W = (LAT_W > 3) ? LAT_W : 3;
    localparam int TMO_W = TO_W + 1;

    typedef struct packed {
        hb_state_e        st;
        logic [CA_W-1:0]  ca;
        logic [SEQ_W-1:0] seq;
        logic [TMO_W-1:0] tmo;
        logic [LEN_W-1:0] left;
        logic             ck;
        logic             vld;
        logic [15:0]      data;
        logic             done;
        logic             err;
    } eng_t;

    eng_t eng_d, eng_q;

    logic        cap_edge;
    logic        cap_word;
    logic [15:0] cap_data;
    logic [TMO_W-1:0] tmo_lim;
    logic [31:0] addr_ext;

    assign tmo_lim  = {cfg_timeout, 1'b0};
    assign addr_ext = 32'(req_addr);

    hb_strobe_capture i_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (eng_q.st == ST_DUMMY),
        .en_i       (eng_q.st == ST_CAPT),
        .rwds_i     (hb_rwds_i),
        .dq_i       (hb_dq_i),
        .edge_o     (cap_edge),
        .word_vld_o (cap_word),
        .word_o     (cap_data)
    );

    hb_wr_latency_check #(
        .LAT_W      (LAT_W),
        .WR_LAT_MIN (WR_LAT_MIN)
    ) i_wrchk (
        .cfg_latency (cfg_latency),
        .wr_lat_ok   (wr_lat_ok)
    );

    always_comb begin
        eng_d      = eng_q;
        eng_d.vld  = 1'b0;
        eng_d.done = 1'b0;
        eng_d.err  = 1'b0;
        case (eng_q.st)
            ST_IDLE: begin
                eng_d.ck = 1'b0;
                if (req_valid) begin
                    eng_d.st   = ST_CMD;
                    eng_d.ca   = build_ca(addr_ext);
                    eng_d.seq  = '0;
                    eng_d.left = req_len;
                end
            end
            ST_CMD: begin
                eng_d.ck  = ~eng_q.ck;
                eng_d.ca  = {eng_q.ca[CA_W-9:0], 8'h00};
                eng_d.seq = eng_q.seq + SEQ_W'(1);
                if (eng_q.seq == SEQ_W'(CA_BYTES - 1)) begin
                    eng_d.st  = ST_DUMMY;
                    eng_d.seq = '0;
                end
            end
            ST_DUMMY: begin
                eng_d.ck  = ~eng_q.ck;
                eng_d.seq = eng_q.seq + SEQ_W'(1);
                if (SEQ_W'(cfg_latency) <= eng_q.seq + SEQ_W'(1)) begin
                    eng_d.st  = ST_CAPT;
                    eng_d.tmo = '0;
                end
            end
            ST_CAPT: begin
                eng_d.ck = ~eng_q.ck;
                if (cap_edge) begin
                    eng_d.tmo = '0;
                    if (cap_word) begin
                        eng_d.vld  = 1'b1;
                        eng_d.data = cap_data;
                        eng_d.left = eng_q.left - LEN_W'(1);
                        if (eng_q.left == LEN_W'(1)) begin
                            eng_d.st   = ST_GAP;
                            eng_d.seq  = '0;
                            eng_d.ck   = 1'b0;
                            eng_d.done = 1'b1;
                        end
                    end
                end else begin
                    eng_d.tmo = eng_q.tmo + TMO_W'(1);
                    if (eng_q.tmo == tmo_lim - TMO_W'(1)) begin
                        eng_d.st   = ST_GAP;
                        eng_d.seq  = '0;
                        eng_d.ck   = 1'b0;
                        eng_d.done = 1'b1;
                        eng_d.err  = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                eng_d.ck  = 1'b0;
                eng_d.seq = eng_q.seq + SEQ_W'(1);
                if (eng_q.seq == SEQ_W'(1)) begin
                    eng_d.st = ST_IDLE;
                end
            end
            default: begin
                eng_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q    <= '0;
            eng_q.st <= ST_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign req_ready = (eng_q.st == ST_IDLE);
    assign hb_cs_n   = !((eng_q.st == ST_CMD) || (eng_q.st == ST_DUMMY) ||
                         (eng_q.st == ST_CAPT));
    assign hb_ck     = eng_q.ck;
    assign hb_dq_o   = eng_q.ca[CA_W-1 -: 8];
    assign hb_dq_oe  = (eng_q.st == ST_CMD);
    assign rd_valid  = eng_q.vld;
    assign rd_data   = eng_q.data;
    assign rd_done   = eng_q.done;
    assign rd_err    = eng_q.err;

    AST_OE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        hb_dq_oe |-> !hb_cs_n); // R2
    AST_CK_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hb_cs_n && $past(!hb_cs_n)) |-> (hb_ck != $past(hb_ck))); // R3
    AST_CK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        hb_cs_n |-> !hb_ck); // R3
    AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !$past(hb_rwds_i)); // R5
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> rd_done); // R8
    AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> hb_cs_n); // R9
    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hb_cs_n) |=> hb_cs_n); // R10
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> hb_cs_n); // R10

endmodule

// File: tb/test_hb_read_engine.sv
module test_hb_read_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_latency = 5'd6;
    logic [7:0]  cfg_timeout = 8'd16;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_len = 8'd1;
    logic        hb_cs_n, hb_ck, hb_dq_oe;
    logic [7:0]  hb_dq_o;
    logic [7:0]  hb_dq_i = '0;
    logic        hb_rwds_i = 1'b0;
    logic        rd_valid, rd_done, rd_err, wr_lat_ok;
    logic [15:0] rd_data;

    always #2.5 clk = ~clk;

    hb_read_engine i_hb_read_engine (
        .clk(clk), .rst_n(rst_n), .cfg_latency(cfg_latency), .cfg_timeout(cfg_timeout),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .hb_cs_n(hb_cs_n), .hb_ck(hb_ck), .hb_dq_o(hb_dq_o), .hb_dq_oe(hb_dq_oe),
        .hb_dq_i(hb_dq_i), .hb_rwds_i(hb_rwds_i), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_done(rd_done), .rd_err(rd_err), .wr_lat_ok(wr_lat_ok)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  len;
        logic [4:0]  lat;
        logic [7:0]  ind;
        logic [7:0]  dlat;
        logic [7:0]  gap_at;
        logic [7:0]  gap_len;
        logic [7:0]  words;
        logic [7:0]  exp_words;
        logic        exp_err;
    } vec_t;

    // capture opens at device cycle 7+lat (cycles counted from chip select fall)
    localparam vec_t VECS [0:6] = '{
        '{32'h0000_1234, 8'd4, 5'd6,  8'd0,  8'd12, 8'd0, 8'd0,  8'd4, 8'd4, 1'b0}, // R5 R9
        '{32'h00AB_CDE7, 8'd6, 5'd11, 8'd0,  8'd30, 8'd0, 8'd0,  8'd6, 8'd6, 1'b0}, // R6
        '{32'h8000_0005, 8'd8, 5'd6,  8'd10, 8'd20, 8'd3, 8'd20, 8'd8, 8'd8, 1'b0}, // R4 R7
        '{32'h0000_0FF8, 8'd5, 5'd6,  8'd0,  8'd13, 8'd2, 8'd1,  8'd5, 8'd5, 1'b0}, // R7
        '{32'h1357_9BDF, 8'd6, 5'd6,  8'd0,  8'd12, 8'd0, 8'd0,  8'd3, 8'd3, 1'b1}, // R8
        '{32'h2222_0000, 8'd3, 5'd2,  8'd0,  8'd10, 8'd0, 8'd0,  8'd3, 8'd3, 1'b0}, // R6
        '{32'h0F0F_0F03, 8'd2, 5'd6,  8'd0,  8'd60, 8'd0, 8'd0,  8'd2, 8'd0, 1'b1}  // R8
    };

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // device model
    int dev_ind = 0, dev_lat = 12, dev_gap_at = 0, dev_gap_len = 0, dev_words = 0;
    logic [15:0] dev_base = '0;
    int dk = 0, db = 0, dp = 0;
    bit dgd = 0;

    function automatic logic [7:0] dbyte(input int b);
        logic [15:0] w;
        w = dev_base + 16'(b / 2);
        return (b % 2 == 1) ? w[7:0] : w[15:8];
    endfunction

    always @(negedge clk) begin
        if (hb_cs_n) begin
            dk = 0; db = 0; dp = 0; dgd = 0;
            hb_rwds_i <= 1'b0;
        end else begin
            dk++;
            if (dk <= dev_ind) hb_rwds_i <= 1'b1;
            else if (dk <= dev_lat) hb_rwds_i <= 1'b0;
            else if (db < 2 * dev_words) begin
                if (db == 2 * dev_gap_at && !dgd && dev_gap_len > 0) begin
                    dp++;
                    if (dp == dev_gap_len) dgd = 1;
                end else begin
                    hb_rwds_i <= ~hb_rwds_i;
                    hb_dq_i   <= dbyte(db);
                    db++;
                end
            end
        end
    end

    // monitor
    logic [15:0] got [0:255];
    logic [7:0]  ca_got [0:127];
    int mon_nw = 0, mon_nca = 0, mon_ndone = 0, mon_lp = 0, mon_tg = 0;
    int mon_ckhi = 0, mon_hirun = 0, mon_lastgap = 0, mon_falls = 0;
    bit mon_err = 0;
    logic prev_cs = 1'b1, prev_ck = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin got[mon_nw[7:0]] = rd_data; mon_nw++; end
            if (hb_dq_oe) begin ca_got[mon_nca[6:0]] = hb_dq_o; mon_nca++; end
            if (rd_done) begin mon_ndone++; mon_err = rd_err; end
            if (!hb_cs_n && !prev_cs) begin
                mon_lp++;
                if (hb_ck != prev_ck) mon_tg++;
            end
            if (hb_cs_n && hb_ck) mon_ckhi++;
            if (hb_cs_n) mon_hirun++;
            else if (prev_cs) begin mon_lastgap = mon_hirun; mon_hirun = 0; mon_falls++; end
            prev_cs = hb_cs_n;
            prev_ck = hb_ck;
        end
    end

    function automatic logic [7:0] ca_exp(input logic [31:0] a, input int i);
        logic [47:0] ca;
        ca = {3'b101, a[31:3], 13'd0, a[2:0]};
        return ca[47 - 8 * i -: 8];
    endfunction

    function automatic string vtag(input int vi);
        case (vi)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            3: return "R7";
            4: return "R8";
            5: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic setup_dev(input vec_t v);
        dev_ind = int'(v.ind); dev_lat = int'(v.dlat);
        dev_gap_at = int'(v.gap_at); dev_gap_len = int'(v.gap_len);
        dev_words = int'(v.words); dev_base = v.addr[15:0] ^ 16'h5A5A;
        cfg_latency = v.lat; req_addr = v.addr; req_len = v.len;
    endtask

    task automatic run_vec(input int vi);
        vec_t v;
        int s_nw, s_ca, s_done, s_lp, s_tg, s_ckhi;
        v = VECS[vi];
        @(negedge clk);
        setup_dev(v);
        s_nw = mon_nw; s_ca = mon_nca; s_done = mon_ndone;
        s_lp = mon_lp; s_tg = mon_tg; s_ckhi = mon_ckhi;
        req_valid = 1'b1;
        @(posedge clk);
        while (!req_ready) @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
        while (mon_ndone == s_done) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(mon_nca - s_ca == 6, "R2", "command byte count", mon_nca - s_ca, 6);
        for (int i = 0; i < 6; i++)
            chk(ca_got[7'(s_ca + i)] == ca_exp(v.addr, i), "R2", "command byte",
                ca_got[7'(s_ca + i)], ca_exp(v.addr, i));
        chk(mon_nw - s_nw == int'(v.exp_words), vtag(vi), "word count",
            mon_nw - s_nw, v.exp_words);
        for (int i = 0; i < int'(v.exp_words); i++)
            chk(got[8'(s_nw + i)] == dev_base + 16'(i), vtag(vi), "word data",
                got[8'(s_nw + i)], dev_base + 16'(i));
        chk(mon_err == v.exp_err, v.exp_err ? "R8" : "R9", "error flag", mon_err, v.exp_err);
        chk(mon_ndone - s_done == 1, "R9", "done pulses", mon_ndone - s_done, 1);
        chk(mon_tg - s_tg == mon_lp - s_lp, "R3", "clock toggles", mon_tg - s_tg, mon_lp - s_lp);
        chk(mon_ckhi == s_ckhi, "R3", "clock high with cs high", mon_ckhi - s_ckhi, 0);
        chk(hb_cs_n == 1'b1, "R9", "cs after burst", hb_cs_n, 1);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000 && !finished) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected below 100000", cyc);
                finished = 1;
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(hb_cs_n == 1'b1, "R1", "cs in reset", hb_cs_n, 1);
        chk(hb_ck == 1'b0, "R1", "ck in reset", hb_ck, 0);
        chk(hb_dq_oe == 1'b0, "R1", "oe in reset", hb_dq_oe, 0);
        chk({rd_valid, rd_done, rd_err} == 3'b000, "R1", "flags in reset",
            {rd_valid, rd_done, rd_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

        // R11 write latency legality
        cfg_latency = 5'd11;
        #1;
        chk(wr_lat_ok == 1'b1, "R11", "latency 11", wr_lat_ok, 1);
        cfg_latency = 5'd10;
        #1;
        chk(wr_lat_ok == 1'b0, "R11", "latency 10", wr_lat_ok, 0);
        cfg_latency = 5'd6;

        for (int vi = 0; vi < 7; vi++) run_vec(vi);

        // R10 back-to-back requests with valid held high
        @(negedge clk);
        setup_dev(VECS[0]);
        f0 = mon_falls;
        req_valid = 1'b1;
        while (mon_falls < f0 + 2) @(negedge clk);
        req_valid = 1'b0;
        chk(mon_lastgap >= 2, "R10", "cs high cycles between bursts", mon_lastgap, 2);
        while (!hb_cs_n) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(mon_falls == f0 + 2, "R10", "bursts started", mon_falls - f0, 2);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule